// File: doc/BRIEF.md
# Tamper Input Glitch-Filtered Detector

This block watches four tamper-sense pins from a slow, always-on clock domain (nominally 32.768 kHz). Each pin is synchronised, and a stability counter measures how long its synchronised value has stayed unchanged. When an enabled channel's settled input equals that channel's programmed trigger level for the selected filter length, the channel's sticky event bit is set. Software clears the bit with a write-one-to-clear status write.

Each channel is configured through a 4-bit group in a shared 32-bit control word. A group holds the enable, the trigger level, a pull-up request for the pad and the filter choice, either short (2 cycles) or long (3071 cycles). Two gates protect the control word. Writes are refused while a lock register is engaged. Writes are also refused while a write-ready flag is low, because each accepted write holds that flag low for a few cycles to model completion across clock domains.

Top module: `tamper_detect`

## Requirements
- R1: After reset the control word reads 0, all event bits are 0, all pull-up requests are 0, the lock is engaged (locked = 1) and writeReady = 1.
- R2: A lock write (wrSel = 1) of the key 0xA3359554 releases the lock (locked = 0). A lock write of any other value engages it (locked = 1). Lock writes do not wait for writeReady.
- R3: A control write (wrSel = 0) made while locked = 1 leaves the control word unchanged and leaves writeReady at 1.
- R4: A control write accepted on a clock edge makes writeReady read 0 for exactly the next 3 cycles. A control write made while writeReady = 0 is ignored.
- R5: Channel n owns control bits 8n+3..8n: bit 8n is enable, bit 8n+1 is trigger level, bit 8n+2 is pull-up request and bit 8n+3 selects the long filter. All other control bits read 0 whatever is written. pullUpReq[n] follows bit 8n+2.
- R6: With the short filter, a pin change that is driven just after edge 0 and then held sets the event on edge 6. A matching pulse that lasts only 3 cycles sets no event.
- R7: With the long filter, a matching pin change driven just after edge 0 and held sets the event on edge 3075, and not before.
- R8: A channel triggers only when its settled input equals its trigger level. Level 1 means a high input triggers and level 0 means a low input triggers.
- R9: An event bit stays set until a status write (wrSel = 2) has a 1 in bit n. If the trigger condition holds in the same cycle as the clear, the bit stays set. Zero bits in the status write have no effect.
- R10: A disabled channel sets no new event and its stability count restarts. Clearing the enable does not clear an event bit that is already latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| wrSel | input | 2 | Write target: 0 control, 1 lock, 2 status clear |
| wrData | input | 32 | Write data |
| tamperPin | input | 4 | Asynchronous tamper pins, one per channel |
| ctrlQ | output | 32 | Current control word |
| eventQ | output | 4 | Sticky tamper event bits |
| pullUpReq | output | 4 | Pull-up request per channel for the pad |
| locked | output | 1 | 1 while control writes are locked out |
| writeReady | output | 1 | 1 when a control write can be accepted |

## Verification
The assertions check a set of rules on every cycle. A locked or busy control write never changes the control word. A dropped writeReady stays low for at least one more cycle. An event bit is never lost without a clear. A disabled channel never sets an event. No event appears before the short filter count is reached, and the stability count never passes the long limit. The bench scenarios are needed for the exact cycle on which an event appears under each filter length, for rejecting a short glitch, for the lock key sequence, for the bit layout of the fields, and for the case where a set and a clear happen in the same cycle.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int NUM_CH    = 4;
  localparam int GRP_STEP  = 8;
  localparam int BIT_EN    = 0;
  localparam int BIT_LVL   = 1;
  localparam int BIT_PU    = 2;
  localparam int BIT_LONG  = 3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOCK = 2'd1,
    SEL_STAT = 2'd2
  } regSel_e;

  typedef struct packed {
    logic [NUM_CH-1:0] chanEn;
    logic [NUM_CH-1:0] chanLvl;
    logic [NUM_CH-1:0] chanLong;
    logic [NUM_CH-1:0] clrMask;
  } ctrlStrobes_t;
endpackage

// File: rtl/tamper_regs.sv
module tamper_regs
  import tamper_pkg::*;
#(
  parameter logic [31:0] LOCK_KEY = 32'hA335_9554,
  parameter int          BUSY_CYC = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [1:0]   wrSel,
  input  logic [31:0]  wrData,
  output logic [31:0]  ctrlQ,
  output logic         locked,
  output logic         writeReady,
  output ctrlStrobes_t strb
);
  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam logic [BW-1:0] BUSY_C = BW'(BUSY_CYC);

  logic [BW-1:0] busyCnt;
  logic [31:0]   ctrlMask;
  logic          ctrlWr, statWr, lockWr;

  assign ctrlWr     = wrEn && (wrSel == SEL_CTRL);
  assign statWr     = wrEn && (wrSel == SEL_STAT);
  assign lockWr     = wrEn && (wrSel == SEL_LOCK);
  assign writeReady = (busyCnt == '0);

  always_comb begin
    ctrlMask = '0;
    for (int g = 0; g < NUM_CH; g++) begin
      ctrlMask[g*GRP_STEP +: 4] = 4'hF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      locked  <= 1'b1;
      busyCnt <= '0;
    end else begin
      if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
      if (lockWr) locked <= (wrData != LOCK_KEY);
      if (ctrlWr && !locked && writeReady) begin
        ctrlQ   <= wrData & ctrlMask;
        busyCnt <= BUSY_C;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      strb.chanEn[c]   = ctrlQ[c*GRP_STEP + BIT_EN];
      strb.chanLvl[c]  = ctrlQ[c*GRP_STEP + BIT_LVL];
      strb.chanLong[c] = ctrlQ[c*GRP_STEP + BIT_LONG];
    end
    strb.clrMask = statWr ? wrData[NUM_CH-1:0] : '0;
  end

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && locked |=> ctrlQ == $past(ctrlQ)); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && !writeReady |=> ctrlQ == $past(ctrlQ)); // R4
  AST_READY_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeReady) |=> !writeReady); // R4
endmodule

// File: rtl/tamper_filter.sv
module tamper_filter
  import tamper_pkg::*;
#(
  parameter int SHORT_LEN = 2,
  parameter int LONG_LEN  = 3071
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pinIn,
  input  ctrlStrobes_t      strb,
  output logic [NUM_CH-1:0] evtQ
);
  localparam int CW = $clog2(LONG_LEN + 1);
  localparam logic [CW-1:0] SHORT_C = CW'(SHORT_LEN);
  localparam logic [CW-1:0] LONG_C  = CW'(LONG_LEN);

  logic [NUM_CH-1:0] hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    logic          syncA, syncB, lastB;
    logic [CW-1:0] stableCnt;
    logic [CW-1:0] limit;

    assign limit  = strb.chanLong[i] ? LONG_C : SHORT_C;
    assign hit[i] = strb.chanEn[i] && (syncB == lastB) &&
                    (stableCnt >= limit) && (syncB == strb.chanLvl[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA     <= 1'b0;
        syncB     <= 1'b0;
        lastB     <= 1'b0;
        stableCnt <= '0;
      end else begin
        syncA <= pinIn[i];
        syncB <= syncA;
        lastB <= syncB;
        if (!strb.chanEn[i] || (syncB != lastB)) stableCnt <= '0;
        else if (stableCnt < LONG_C) stableCnt <= stableCnt + 1'b1;
      end
    end

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rstN)
      stableCnt <= LONG_C); // R7
    AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rstN)
      !evtQ[i] && (stableCnt < SHORT_C) |=> !evtQ[i]); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      evtQ[i] && !strb.clrMask[i] |=> evtQ[i]); // R9
    AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      !strb.chanEn[i] && !evtQ[i] |=> !evtQ[i]); // R10
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtQ <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (hit[c]) evtQ[c] <= 1'b1;
        else if (strb.clrMask[c]) evtQ[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tamper_detect.sv
module tamper_detect
  import tamper_pkg::*;
#(
  parameter logic [31:0] LOCK_KEY  = 32'hA335_9554,
  parameter int          BUSY_CYC  = 3,
  parameter int          SHORT_LEN = 2,
  parameter int          LONG_LEN  = 3071
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [31:0] wrData,
  input  logic [3:0]  tamperPin,
  output logic [31:0] ctrlQ,
  output logic [3:0]  eventQ,
  output logic [3:0]  pullUpReq,
  output logic        locked,
  output logic        writeReady
);
  ctrlStrobes_t strb;

  tamper_regs #(.LOCK_KEY(LOCK_KEY), .BUSY_CYC(BUSY_CYC)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .ctrlQ(ctrlQ), .locked(locked), .writeReady(writeReady), .strb(strb)
  );

  tamper_filter #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) uFilt (
    .clk(clk), .rstN(rstN), .pinIn(tamperPin), .strb(strb), .evtQ(eventQ)
  );

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) pullUpReq[c] = ctrlQ[c*GRP_STEP + BIT_PU];
  end
endmodule

// File: tb/tb_tamper_detect.sv
module tb_tamper_detect;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [31:0] wrData = '0;
  logic [3:0]  tamperPin = '0;
  logic [31:0] ctrlQ;
  logic [3:0]  eventQ, pullUpReq;
  logic        locked, writeReady;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    int          sel;
    logic [31:0] exp;
  } expItem_t;
  expItem_t expQ[$];
  event chkEv;

  tamper_detect dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .tamperPin(tamperPin), .ctrlQ(ctrlQ), .eventQ(eventQ),
    .pullUpReq(pullUpReq), .locked(locked), .writeReady(writeReady)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0: return ctrlQ;
      1: return {28'd0, eventQ};
      2: return {31'd0, locked};
      3: return {31'd0, writeReady};
      default: return {28'd0, pullUpReq};
    endcase
  endfunction

  initial begin : monitor
    forever begin
      @(chkEv);
      while (expQ.size() > 0) begin
        expItem_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        act = observe(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expectVal(string tag, int sel, logic [31:0] exp);
    expItem_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    expQ.push_back(it);
    -> chkEv;
    #1;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(logic [1:0] sel, logic [31:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic waitReady();
    while (!writeReady) tick(1);
  endtask

  task automatic finishRun();
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin : driver
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    expectVal("R1 ctrl", 0, 32'h0);
    expectVal("R1 events", 1, 32'h0);
    expectVal("R1 pullup", 4, 32'h0);
    expectVal("R1 locked", 2, 32'h1);
    expectVal("R1 ready", 3, 32'h1);

    // R3 locked write ignored
    writeReg(2'd0, 32'hFFFF_FFFF);
    expectVal("R3 ctrl unchanged", 0, 32'h0);
    expectVal("R3 ready stays", 3, 32'h1);

    // R2 lock key handling
    writeReg(2'd1, 32'h1234_5678);
    expectVal("R2 wrong key", 2, 32'h1);
    writeReg(2'd1, 32'hA335_9554);
    expectVal("R2 key unlocks", 2, 32'h0);

    // R5 layout: ch0 en|lvl1 short, ch1 off, ch2 all set long, ch3 en|lvl0|pu short
    writeReg(2'd0, 32'hF5FF_F0F3);
    expectVal("R5 ctrl masked", 0, 32'h050F_0003);
    expectVal("R5 pullup", 4, 32'h0000_000C);
    // R4 busy window
    expectVal("R4 ready low", 3, 32'h0);
    writeReg(2'd0, 32'h0);
    expectVal("R4 busy write ignored", 0, 32'h050F_0003);
    expectVal("R4 ready still low", 3, 32'h0);
    tick(1);
    expectVal("R4 ready low third cycle", 3, 32'h0);
    tick(1);
    expectVal("R4 ready back", 3, 32'h1);

    // R8 ch3 level 0 with low pin triggers; ch0 level 1 does not
    tick(6);
    expectVal("R8 low level triggers", 1, 32'h8);

    // R9 clear while condition holds: set wins
    writeReg(2'd2, 32'h8);
    expectVal("R9 set wins", 1, 32'h8);

    // R6 glitch of 3 cycles on ch0 ignored
    tamperPin[0] = 1'b1;
    tick(3);
    tamperPin[0] = 1'b0;
    tick(8);
    expectVal("R6 glitch ignored", 1, 32'h8);

    // R6 short filter exact timing
    tamperPin[0] = 1'b1;
    tick(5);
    expectVal("R6 not before edge 6", 1, 32'h8);
    tick(1);
    expectVal("R6 set at edge 6", 1, 32'h9);

    // R7 long filter on ch2
    tamperPin[2] = 1'b1;
    tick(3074);
    expectVal("R7 not before edge 3075", 1, 32'h9);
    tick(1);
    expectVal("R7 set at edge 3075", 1, 32'hD);

    // R9 zero bits no effect, then clear ch0 after pin returns low
    writeReg(2'd2, 32'h0);
    expectVal("R9 zero write no effect", 1, 32'hD);
    tamperPin[0] = 1'b0;
    tick(4);
    writeReg(2'd2, 32'h1);
    expectVal("R9 clear ch0", 1, 32'hC);

    // R10 disable keeps latched event, then no new events
    waitReady();
    writeReg(2'd0, 32'h000F_0003);
    expectVal("R10 ctrl ch3 off", 0, 32'h000F_0003);
    expectVal("R10 latched kept", 1, 32'hC);
    writeReg(2'd2, 32'h8);
    tick(12);
    expectVal("R10 no new event", 1, 32'h4);

    // R2 relock then R3 write blocked
    waitReady();
    writeReg(2'd1, 32'h0);
    expectVal("R2 relocked", 2, 32'h1);
    writeReg(2'd0, 32'h0);
    expectVal("R3 relocked write ignored", 0, 32'h000F_0003);

    done = 1'b1;
    finishRun();
  end
endmodule